// File: doc/BRIEF.md
# I2C Controller Command and Participation Register

This block holds the 8-bit command register of an I2C bus controller and runs the sequencing behind it. Software writes and reads the register through a plain one-cycle write port with a combinational read-back. The block takes start, stop, address-match and extended-code events from a separate bus condition detector. From these it drives the open-drain pull-down enables for SCL and SDA, a wait-release pulse, a gated stop-condition interrupt, a preset level for the status register, and clear strobes for the status flags.

The global enable decides the overall behaviour. While it is low, both bus lines are pulled low, the status register is held in preset, and the command bits that need an active controller cannot be set. A release command takes the controller off the bus at once. It floats both lines, clears the transfer-related status flags and the start and stop trigger bits, and leaves the controller in a non-participating state. The controller stays there until a stop condition is seen, which allows a later master start. It also leaves that state when an address match or an extended code arrives after a start condition, so it can answer as a slave. The wait-timing and acknowledge-enable fields have no function here. They are stored and passed on to neighbouring blocks.

Top module: `i2c_ctl_reg`

## Requirements
- R1: After reset the register reads 0x00, both `scl_oe` and `sda_oe` are 1, `stat_preset` is 1, and `stop_irq`, `wait_rel_pulse` and `flag_clr` are 0.
- R2: While the enable (bit 7) reads 0, `scl_oe` and `sda_oe` are both 1 and `stat_preset` is 1, whatever the values of `scl_tx_low` and `sda_tx_low`.
- R3: Bit positions are: 7 enable, 6 release, 5 wait release, 4 stop-interrupt enable, 3 wait timing, 2 acknowledge enable, 1 start trigger, 0 stop trigger. Bits 4..0 read back as written and bits 3..0 appear on `wait_tim`, `ack_en`, `start_req` and `stop_req`.
- R4: A write whose bit 7 is 0 stores bits 6, 5 and 4 as 0.
- R5: A write with bits 7 and 6 both 1 makes bit 6 read 1 for exactly the next cycle and 0 after that. In that one cycle all bits of `flag_clr` are 1 (one strobe per status flag: start detected, acknowledge detected, transmit mode, address match, extended code, master status, start trigger, stop trigger). Bits 1 and 0 are stored as 0.
- R6: From the cycle after a release write, `scl_oe` and `sda_oe` are 0, whatever `scl_tx_low` and `sda_tx_low` are, until the controller rejoins.
- R7: A rising edge on `stop_det` while the controller is released makes it rejoin, and from the next cycle the line enables follow `scl_tx_low` and `sda_tx_low` again.
- R8: While the controller is released, `addr_match` or `ext_code` makes it rejoin only when a rising edge of `start_det` has been seen since the release. Without that start, they leave the lines floating.
- R9: A `wait_req` pulse while the controller is enabled and participating holds `scl_oe` at 1 until a write with bits 7 and 5 both 1. From the next cycle `scl_oe` follows `scl_tx_low`, bit 5 reads 1 for one cycle, and `wait_rel_pulse` is 1 for that one cycle.
- R10: A rising edge of `stop_det` with bits 7 and 4 set gives a one-cycle `stop_irq` in the following cycle, even when `stop_det` stays high. With bit 4 clear it gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read-back |
| start_det | input | 1 | Start condition detected |
| stop_det | input | 1 | Stop condition detected |
| addr_match | input | 1 | Own slave address matched |
| ext_code | input | 1 | Extended code received |
| wait_req | input | 1 | Wait request from the byte engine |
| scl_tx_low | input | 1 | Byte engine wants SCL low |
| sda_tx_low | input | 1 | Byte engine wants SDA low |
| scl_oe | output | 1 | SCL pull-down enable |
| sda_oe | output | 1 | SDA pull-down enable |
| wait_rel_pulse | output | 1 | One-cycle wait release |
| stop_irq | output | 1 | Stop-condition interrupt pulse |
| flag_clr | output | 8 | Status flag clear strobes |
| stat_preset | output | 1 | Status register preset level |
| wait_tim | output | 1 | Wait timing field |
| ack_en | output | 1 | Acknowledge enable field |
| start_req | output | 1 | Start trigger field |
| stop_req | output | 1 | Stop trigger field |

## Verification
The bench checks that an address match arriving with no start before it leaves the lines floating. A design that skipped the start qualifier would grab SDA in the middle of a foreign transfer. It holds `stop_det` high for several cycles and expects only one interrupt pulse. A level-triggered design would raise the interrupt again and again. It also writes the release, wait-release and stop-interrupt-enable bits together with a cleared enable and expects them to read 0, and it checks that a release clears the start and stop triggers and pulses every flag clear for exactly one cycle. A design that kept the trigger bits would restart a transfer after leaving the bus.

// File: rtl/i2cc_pkg.sv
package i2cc_pkg;
   localparam int CTL_W   = 8;
   localparam int B_EN    = 7;
   localparam int B_REL   = 6;
   localparam int B_WREL  = 5;
   localparam int B_STIE  = 4;
   localparam int B_WTIM  = 3;
   localparam int B_ACKE  = 2;
   localparam int B_STRT  = 1;
   localparam int B_STP   = 0;

   localparam int NUM_EV  = 4;
   localparam int EV_START = 0;
   localparam int EV_STOP  = 1;
   localparam int EV_ADDR  = 2;
   localparam int EV_EXT   = 3;

   typedef enum logic [1:0] {
      PS_OFF      = 2'd0,
      PS_ACTIVE   = 2'd1,
      PS_DETACHED = 2'd2,
      PS_ARMED    = 2'd3
   } part_st_t;
endpackage

// File: rtl/i2cc_event_in.sv
module i2cc_event_in #(
   parameter int N         = 4,
   parameter int STAGES    = 0,
   parameter logic [N-1:0] EDGE_MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev_in,
   output logic [N-1:0] ev_out
);
   logic [N-1:0] ev_sync;
   logic [N-1:0] ev_prev;

   generate
      if (STAGES == 0) begin : g_direct
         assign ev_sync = ev_in;
      end else begin : g_sync
         logic [N-1:0] chain [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) chain[s] <= '0;
            end else begin
               chain[0] <= ev_in;
               for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
            end
         end
         assign ev_sync = chain[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ev_prev <= '0;
      else        ev_prev <= ev_sync;
   end

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         if (EDGE_MASK[i]) begin : g_edge
            assign ev_out[i] = ev_sync[i] & ~ev_prev[i];
         end else begin : g_level
            assign ev_out[i] = ev_sync[i];
         end
      end
   endgenerate
endmodule

// File: rtl/i2cc_part_fsm.sv
module i2cc_part_fsm
   import i2cc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en_nxt,
   input  logic release_cmd,
   input  logic start_rise,
   input  logic stop_rise,
   input  logic addr_hit,
   input  logic ext_hit,
   output logic active
);
   part_st_t st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (!en_nxt) begin
         st_d = PS_OFF;
      end else if (release_cmd) begin
         st_d = PS_DETACHED;
      end else begin
         unique case (st_q)
            PS_OFF:      st_d = PS_ACTIVE;
            PS_ACTIVE:   st_d = PS_ACTIVE;
            PS_DETACHED: begin
               if (stop_rise)       st_d = PS_ACTIVE;
               else if (start_rise) st_d = PS_ARMED;
            end
            PS_ARMED: begin
               if (stop_rise || addr_hit || ext_hit) st_d = PS_ACTIVE;
            end
            default:     st_d = PS_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= PS_OFF;
      else        st_q <= st_d;
   end

   assign active = (st_q == PS_ACTIVE);
endmodule

// File: rtl/i2cc_line_drv.sv
module i2cc_line_drv (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic active,
   input  logic wait_req,
   input  logic wait_release,
   input  logic scl_tx_low,
   input  logic sda_tx_low,
   output logic scl_oe,
   output logic sda_oe
);
   logic wait_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             wait_hold <= 1'b0;
      else if (!en || !active || wait_release) wait_hold <= 1'b0;
      else if (wait_req)                      wait_hold <= 1'b1;
   end

   assign scl_oe = ~en | (active & (wait_hold | scl_tx_low));
   assign sda_oe = ~en | (active & sda_tx_low);
endmodule

// File: rtl/i2c_ctl_reg.sv
module i2c_ctl_reg
   import i2cc_pkg::*;
#(
   parameter int CTL_BITS    = 8,
   parameter int NUM_FLAGS   = 8,
   parameter int SYNC_STAGES = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [CTL_BITS-1:0]  wr_data,
   output logic [CTL_BITS-1:0]  rd_data,
   input  logic                 start_det,
   input  logic                 stop_det,
   input  logic                 addr_match,
   input  logic                 ext_code,
   input  logic                 wait_req,
   input  logic                 scl_tx_low,
   input  logic                 sda_tx_low,
   output logic                 scl_oe,
   output logic                 sda_oe,
   output logic                 wait_rel_pulse,
   output logic                 stop_irq,
   output logic [NUM_FLAGS-1:0] flag_clr,
   output logic                 stat_preset,
   output logic                 wait_tim,
   output logic                 ack_en,
   output logic                 start_req,
   output logic                 stop_req
);
   localparam logic [NUM_EV-1:0] EDGE_SEL = NUM_EV'((1 << EV_START) | (1 << EV_STOP));

   generate
      if (CTL_BITS != CTL_W) begin : g_bad_width
         $error("i2c_ctl_reg: CTL_BITS must equal %0d", CTL_W);
      end
      if (NUM_FLAGS < 1) begin : g_bad_flags
         $error("i2c_ctl_reg: NUM_FLAGS must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("i2c_ctl_reg: SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic [CTL_BITS-1:0] ctl_q, ctl_d;
   logic                release_cmd, wrel_cmd;
   logic [NUM_EV-1:0]   ev_raw, ev;
   logic                active;
   logic                irq_q;

   // Command decode uses the enable being written
   assign release_cmd = wr_en & wr_data[B_EN] & wr_data[B_REL];
   assign wrel_cmd    = wr_en & wr_data[B_EN] & wr_data[B_WREL];

   always_comb begin
      ctl_d         = ctl_q;
      ctl_d[B_REL]  = 1'b0;
      ctl_d[B_WREL] = 1'b0;
      if (wr_en) begin
         ctl_d = wr_data;
         if (!wr_data[B_EN]) begin
            ctl_d[B_REL]  = 1'b0;
            ctl_d[B_WREL] = 1'b0;
            ctl_d[B_STIE] = 1'b0;
         end
         if (release_cmd) begin
            ctl_d[B_STRT] = 1'b0;
            ctl_d[B_STP]  = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q <= '0;
      else        ctl_q <= ctl_d;
   end

   assign ev_raw[EV_START] = start_det;
   assign ev_raw[EV_STOP]  = stop_det;
   assign ev_raw[EV_ADDR]  = addr_match;
   assign ev_raw[EV_EXT]   = ext_code;

   i2cc_event_in #(
      .N         (NUM_EV),
      .STAGES    (SYNC_STAGES),
      .EDGE_MASK (EDGE_SEL)
   ) u_events (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev_in  (ev_raw),
      .ev_out (ev)
   );

   i2cc_part_fsm u_part (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_nxt      (ctl_d[B_EN]),
      .release_cmd (release_cmd),
      .start_rise  (ev[EV_START]),
      .stop_rise   (ev[EV_STOP]),
      .addr_hit    (ev[EV_ADDR]),
      .ext_hit     (ev[EV_EXT]),
      .active      (active)
   );

   i2cc_line_drv u_lines (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (ctl_q[B_EN]),
      .active       (active),
      .wait_req     (wait_req),
      .wait_release (wrel_cmd),
      .scl_tx_low   (scl_tx_low),
      .sda_tx_low   (sda_tx_low),
      .scl_oe       (scl_oe),
      .sda_oe       (sda_oe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= ctl_q[B_EN] & ctl_q[B_STIE] & ev[EV_STOP];
   end

   assign rd_data        = ctl_q;
   assign stop_irq       = irq_q;
   assign wait_rel_pulse = ctl_q[B_WREL];
   assign flag_clr       = {NUM_FLAGS{ctl_q[B_REL]}};
   assign stat_preset    = ~ctl_q[B_EN];
   assign wait_tim       = ctl_q[B_WTIM];
   assign ack_en         = ctl_q[B_ACKE];
   assign start_req      = ctl_q[B_STRT];
   assign stop_req       = ctl_q[B_STP];
endmodule

module i2c_ctl_reg_chk #(
   parameter int NF = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [7:0]    wr_data,
   input logic [7:0]    rd_data,
   input logic          stop_irq,
   input logic          scl_oe,
   input logic          sda_oe,
   input logic [NF-1:0] flag_clr,
   input logic          stat_preset
);
   // R2
   disabled_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_preset |-> (scl_oe && sda_oe));

   // R3
   field_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[7] && !wr_data[6]) |=> (rd_data[3:0] == $past(wr_data[3:0])));

   // R4
   enable_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[7] |-> (rd_data[6:4] == 3'b000));

   // R5
   release_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[6] |=> (!rd_data[6] || $past(wr_en && wr_data[7] && wr_data[6])));

   // R5
   release_trig_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr != '0) |-> (rd_data[1:0] == 2'b00));

   // R6
   release_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en && wr_data[7] && wr_data[6]) |-> (!scl_oe && !sda_oe));

   // R9
   wrel_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[5] |=> (!rd_data[5] || $past(wr_en && wr_data[7] && wr_data[5])));

   // R10
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_irq |=> !stop_irq);

   // R10
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_irq |-> $past(rd_data[4] && rd_data[7]));
endmodule

bind i2c_ctl_reg i2c_ctl_reg_chk #(.NF(NUM_FLAGS)) u_chk (.*);

// File: tb/i2c_ctl_reg_bench.sv
module i2c_ctl_reg_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       start_det = 1'b0, stop_det = 1'b0, addr_match = 1'b0, ext_code = 1'b0;
   logic       wait_req = 1'b0, scl_tx_low = 1'b0, sda_tx_low = 1'b0;
   logic       scl_oe, sda_oe, wait_rel_pulse, stop_irq, stat_preset;
   logic       wait_tim, ack_en, start_req, stop_req;
   logic [7:0] flag_clr;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;

   i2c_ctl_reg u_i2c_ctl_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .start_det(start_det), .stop_det(stop_det), .addr_match(addr_match),
      .ext_code(ext_code), .wait_req(wait_req), .scl_tx_low(scl_tx_low),
      .sda_tx_low(sda_tx_low), .scl_oe(scl_oe), .sda_oe(sda_oe),
      .wait_rel_pulse(wait_rel_pulse), .stop_irq(stop_irq), .flag_clr(flag_clr),
      .stat_preset(stat_preset), .wait_tim(wait_tim), .ack_en(ack_en),
      .start_req(start_req), .stop_req(stop_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Read-back in the cycle right after a write of d
   function automatic logic [7:0] exp_after_write(input logic [7:0] d);
      logic [7:0] r = d;
      if (!d[7]) r[6:4] = 3'b000;
      if (d[7] && d[6]) r[1:0] = 2'b00;
      return r;
   endfunction

   // Read-back once self-clearing bits have dropped
   function automatic logic [7:0] exp_settled(input logic [7:0] d);
      return exp_after_write(d) & 8'h9F;
   endfunction

   task automatic write_reg(input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic pulse(ref logic sig);
      @(negedge clk); sig = 1'b1;
      @(negedge clk); sig = 1'b0;
   endtask

   initial begin
      #(20 * 20000);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 rd_data", rd_data, 8'h00);
      check("R1 lines", {scl_oe, sda_oe, stat_preset}, 3'b111);
      check("R1 pulses", {stop_irq, wait_rel_pulse, flag_clr}, 10'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 disabled drives low regardless of tx
      scl_tx_low = 1'b0; sda_tx_low = 1'b0;
      @(negedge clk);
      check("R2 disabled lines", {scl_oe, sda_oe, stat_preset}, 3'b111);

      // R4 masked bits when enable is 0
      write_reg(8'h7F);
      check("R4 masked read", rd_data, 8'h0F);
      check("R3 fields out", {wait_tim, ack_en, start_req, stop_req}, 4'hF);
      check("R2 disabled after write", {scl_oe, sda_oe}, 2'b11);

      // enable, check participation follows tx
      write_reg(8'h80);
      sda_tx_low = 1'b1;
      @(negedge clk);
      check("R2 enabled follows tx", {scl_oe, sda_oe, stat_preset}, 3'b010);

      // R5 release with triggers set
      write_reg(8'h83);
      check("R3 triggers stored", rd_data, 8'h83);
      write_reg(8'hC3);
      check("R5 release reads one", rd_data, 8'hC0);
      check("R5 flag_clr strobe", flag_clr, 8'hFF);
      check("R6 lines float", {scl_oe, sda_oe}, 2'b00);
      @(negedge clk);
      check("R5 release self clear", rd_data, 8'h80);
      check("R5 flag_clr done", flag_clr, 8'h00);
      scl_tx_low = 1'b1;
      @(negedge clk);
      check("R6 still floating", {scl_oe, sda_oe}, 2'b00);
      scl_tx_low = 1'b0;

      // R8 address match without start is ignored
      pulse(addr_match);
      check("R8 addr without start", sda_oe, 1'b0);
      pulse(ext_code);
      check("R8 ext without start", sda_oe, 1'b0);
      pulse(start_det);
      check("R8 start alone", sda_oe, 1'b0);
      pulse(addr_match);
      check("R8 rejoin on addr", sda_oe, 1'b1);

      // R8 ext code path
      write_reg(8'hC0);
      pulse(start_det);
      pulse(ext_code);
      check("R8 rejoin on ext", sda_oe, 1'b1);

      // R7 stop rejoin
      write_reg(8'hC0);
      check("R7 released", sda_oe, 1'b0);
      pulse(stop_det);
      check("R7 rejoin on stop", sda_oe, 1'b1);

      // R9 wait hold and release
      sda_tx_low = 1'b0;
      pulse(wait_req);
      check("R9 wait holds scl", scl_oe, 1'b1);
      repeat (3) @(negedge clk);
      check("R9 wait still held", scl_oe, 1'b1);
      write_reg(8'hA0);
      check("R9 scl freed", scl_oe, 1'b0);
      check("R9 wrel reads one", rd_data, 8'hA0);
      check("R9 wrel pulse", wait_rel_pulse, 1'b1);
      @(negedge clk);
      check("R9 wrel self clear", {rd_data, wait_rel_pulse}, {8'h80, 1'b0});

      // R10 stop irq held stop gives one pulse
      write_reg(8'h90);
      @(negedge clk); stop_det = 1'b1;
      @(negedge clk);
      check("R10 irq pulse", stop_irq, 1'b1);
      @(negedge clk);
      check("R10 irq single", stop_irq, 1'b0);
      repeat (3) @(negedge clk);
      check("R10 no repeat", stop_irq, 1'b0);
      stop_det = 1'b0;

      // random field writes and gated stop interrupt
      void'($urandom(32'h1C2B));
      for (int i = 0; i < 40; i++) begin
         logic [7:0] d;
         d = 8'($urandom) & 8'h9F;
         d[7] = 1'b1;
         write_reg(d);
         check("R3 random read", rd_data, exp_settled(d));
         check("R3 random outs", {wait_tim, ack_en, start_req, stop_req}, d[3:0]);
         @(negedge clk); stop_det = 1'b1;
         @(negedge clk);
         check("R10 random gate", stop_irq, d[4]);
         stop_det = 1'b0;
         @(negedge clk);
         check("R10 random drop", stop_irq, 1'b0);
      end

      // R4 random disabled writes
      for (int i = 0; i < 10; i++) begin
         logic [7:0] d;
         d = 8'($urandom) & 8'h7F;
         write_reg(d);
         check("R4 random masked", rd_data, exp_after_write(d));
         check("R2 random disabled", {scl_oe, sda_oe, stat_preset}, 3'b111);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule